// File: doc/BRIEF.md
# Phase-Staggered Eight-Channel PWM Dimmer

This block drives eight LED bypass switches from one shared dimming clock. Each switch output shorts its LED segment when high ("switch on", LED dark) and lets the string current through when low ("switch off", LED lit). A channel can be held constantly on, held constantly off, or pulse-width modulated from an 8-bit brightness value. One dimming cycle spans 2048 dimming ticks, so each brightness step is worth 8 ticks.

Dimming ticks come either from an internal-oscillator tick enable or from a free-running external clock pin. The external pin is synchronized, and each rising edge becomes one tick. At reset, and again each time the enable input rises, the eight channel counters are spread by one eighth of a cycle. Their LED-on edges therefore never land on the same tick. Each channel follows either a shared group word or its own mode register, whichever was written last. A new brightness value is applied only at the start of the channel's next cycle.

Top module: `stagger_dimmer`

## Requirements
- R1: While reset is asserted and after it is released, every switch output is low, because the group word resets to all ones (GRP_RST_ONES=1) and all channels start under group control; channel k's counter starts 256·k ticks behind channel 0.
- R2: Under group control, bit k of the group word selects channel k: 1 gives switch off (output low) and 0 gives switch on (output high), visible the cycle after the write.
- R3: A channel write with mode code 0 forces that switch off, and mode code 1 forces it on, from the cycle after the write.
- R4: A group write returns every channel to group control. A channel write puts that channel under its own register. When both writes occur in the same cycle, the channel write wins for the channels it names.
- R5: In PWM mode (code 2 or 3), the switch goes low at the tick where the channel counter wraps to 0. It goes high when the counter reaches value·8 and stays high until the next wrap, so the LED is lit for value·8 ticks out of 2048. A value of 0 keeps the switch high for the whole cycle.
- R6: Each channel's cycle starts exactly 256 ticks after that of the channel below it.
- R7: A brightness value written in the middle of a cycle has no effect on the current cycle. It is loaded at the channel's next wrap.
- R8: With the source select at 0, the oscillator tick enable advances the counters. With the select at 1, only synchronized rising edges of the external clock advance them, and the counters hold while that clock is idle.
- R9: While enable is low, all switch outputs are low, and all state is held at its reset value, so writes made in that time are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable; low forces switches off and clears state |
| osc_tick_i | input | 1 | Internal oscillator dimming tick enable |
| ext_clk_i | input | 1 | External dimming clock, asynchronous |
| src_sel_i | input | 1 | Tick source: 0 oscillator, 1 external clock |
| grp_we_i | input | 1 | Group word write strobe |
| grp_wdata_i | input | NUM_CH | Group word, 1 = switch off |
| ch_we_i | input | NUM_CH | Per-channel write strobes |
| ch_mode_i | input | 2 | Channel mode: 0 off, 1 on, 2/3 PWM |
| ch_val_i | input | VAL_W | Channel brightness value |
| sw_on_o | output | NUM_CH | Bypass switch controls, 1 = LED bypassed |

## Verification
The bench builds the block with its default parameters: eight channels, 8-bit values, three step bits and a two-stage synchronizer. With these values the full 2048-tick cycle and the 256-tick stagger are measured in absolute clock counts after an enable rise. Extreme brightness values (0, 1 and 255) are reached, and the external clock is driven at a quarter of the system rate, so the measured LED-on widths scale by exactly four. The group-reset variant that resets to all zeros is not built.

// File: rtl/dim_pkg.sv
package dim_pkg;
  typedef enum logic [1:0] {
    MODE_SW_OFF = 2'd0,
    MODE_SW_ON  = 2'd1,
    MODE_PWM    = 2'd2,
    MODE_PWM_B  = 2'd3
  } ch_mode_e;
endpackage

// File: rtl/dim_tick_src.sv
module dim_tick_src #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_tick_i,
  input  logic ext_clk_i,
  input  logic src_sel_i,
  output logic tick_o
);
  // stage SYNC_STAGES holds the previous synchronized level for edge detect
  logic [SYNC_STAGES:0] pipe_q;
  logic                 ext_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[SYNC_STAGES-1:0], ext_clk_i};
  end

  assign ext_rise = pipe_q[SYNC_STAGES-1] & ~pipe_q[SYNC_STAGES];
  assign tick_o   = src_sel_i ? ext_rise : osc_tick_i;
endmodule

// File: rtl/dim_ctrl_sel.sv
module dim_ctrl_sel #(
  parameter int unsigned NUM_CH       = 8,
  parameter bit          GRP_RST_ONES = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              grp_we_i,
  input  logic [NUM_CH-1:0] grp_wdata_i,
  input  logic [NUM_CH-1:0] ch_we_i,
  output logic [NUM_CH-1:0] grp_q_o,
  output logic [NUM_CH-1:0] use_ch_o
);
  localparam logic [NUM_CH-1:0] GRP_RST = {NUM_CH{GRP_RST_ONES}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       grp_q_o <= GRP_RST;
    else if (clr_i)    grp_q_o <= GRP_RST;
    else if (grp_we_i) grp_q_o <= grp_wdata_i;
  end

  // last writer owns the channel; a channel write beats a same-cycle group write
  for (genvar k = 0; k < NUM_CH; k++) begin : g_own
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         use_ch_o[k] <= 1'b0;
      else if (clr_i)      use_ch_o[k] <= 1'b0;
      else if (ch_we_i[k]) use_ch_o[k] <= 1'b1;
      else if (grp_we_i)   use_ch_o[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/dim_channel.sv
module dim_channel
  import dim_pkg::*;
#(
  parameter int unsigned CH_IDX = 0,
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned VAL_W  = 8,
  parameter int unsigned STEP_W = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    tick_i,
  input  logic                    we_i,
  input  logic [1:0]              mode_i,
  input  logic [VAL_W-1:0]        val_i,
  input  logic                    use_ch_i,
  input  logic                    grp_bit_i,
  output logic                    sw_on_o,
  output logic [VAL_W+STEP_W-1:0] cnt_o
);
  localparam int unsigned CNT_W   = VAL_W + STEP_W;
  localparam int unsigned CYC     = 1 << CNT_W;
  localparam int unsigned PHASE   = CYC / NUM_CH;
  localparam int unsigned RST_CNT = (CYC - CH_IDX * PHASE) % CYC;
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(RST_CNT);

  ch_mode_e         mode_q;
  logic [VAL_W-1:0] val_q, act_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wrap, pwm_on;

  assign wrap = tick_i & (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_SW_OFF;
      val_q  <= '0;
      act_q  <= '0;
      cnt_q  <= CNT_INIT;
    end else if (clr_i) begin
      mode_q <= MODE_SW_OFF;
      val_q  <= '0;
      act_q  <= '0;
      cnt_q  <= CNT_INIT;
    end else begin
      if (we_i) begin
        mode_q <= ch_mode_e'(mode_i);
        val_q  <= val_i;
      end
      if (tick_i) cnt_q <= cnt_q + 1'b1;
      // value takes effect only at the cycle boundary
      if (wrap) act_q <= val_q;
    end
  end

  // LED lit while counter is below value*8
  assign pwm_on = cnt_q >= {act_q, {STEP_W{1'b0}}};

  always_comb begin
    if (!use_ch_i) sw_on_o = ~grp_bit_i;
    else begin
      unique case (mode_q)
        MODE_SW_OFF: sw_on_o = 1'b0;
        MODE_SW_ON:  sw_on_o = 1'b1;
        default:     sw_on_o = pwm_on;
      endcase
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/stagger_dimmer.sv
module stagger_dimmer #(
  parameter int unsigned NUM_CH       = 8,
  parameter int unsigned VAL_W        = 8,
  parameter int unsigned STEP_W       = 3,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter bit          GRP_RST_ONES = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              osc_tick_i,
  input  logic              ext_clk_i,
  input  logic              src_sel_i,
  input  logic              grp_we_i,
  input  logic [NUM_CH-1:0] grp_wdata_i,
  input  logic [NUM_CH-1:0] ch_we_i,
  input  logic [1:0]        ch_mode_i,
  input  logic [VAL_W-1:0]  ch_val_i,
  output logic [NUM_CH-1:0] sw_on_o
);
  localparam int unsigned CNT_W = VAL_W + STEP_W;

  logic                         tick, clr;
  logic [NUM_CH-1:0]            grp_q, use_ch, ch_sw;
  logic [NUM_CH-1:0][CNT_W-1:0] cnt_all;

  assign clr = ~en_i;

  dim_tick_src #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .osc_tick_i (osc_tick_i),
    .ext_clk_i  (ext_clk_i),
    .src_sel_i  (src_sel_i),
    .tick_o     (tick)
  );

  dim_ctrl_sel #(.NUM_CH(NUM_CH), .GRP_RST_ONES(GRP_RST_ONES)) u_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .grp_we_i    (grp_we_i),
    .grp_wdata_i (grp_wdata_i),
    .ch_we_i     (ch_we_i),
    .grp_q_o     (grp_q),
    .use_ch_o    (use_ch)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dim_channel #(
      .CH_IDX (i),
      .NUM_CH (NUM_CH),
      .VAL_W  (VAL_W),
      .STEP_W (STEP_W)
    ) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (clr),
      .tick_i    (tick),
      .we_i      (ch_we_i[i]),
      .mode_i    (ch_mode_i),
      .val_i     (ch_val_i),
      .use_ch_i  (use_ch[i]),
      .grp_bit_i (grp_q[i]),
      .sw_on_o   (ch_sw[i]),
      .cnt_o     (cnt_all[i])
    );
  end

  assign sw_on_o = ch_sw & {NUM_CH{en_i}};
endmodule

// File: rtl/stagger_dimmer_chk.sv
module stagger_dimmer_chk #(
  parameter int unsigned NUM_CH       = 8,
  parameter int unsigned VAL_W        = 8,
  parameter int unsigned STEP_W       = 3,
  parameter bit          GRP_RST_ONES = 1'b1
) (
  input logic                                       clk_i,
  input logic                                       rst_ni,
  input logic                                       en_i,
  input logic                                       osc_tick_i,
  input logic                                       src_sel_i,
  input logic                                       grp_we_i,
  input logic [NUM_CH-1:0]                          grp_wdata_i,
  input logic [NUM_CH-1:0]                          ch_we_i,
  input logic [1:0]                                 ch_mode_i,
  input logic [NUM_CH-1:0]                          sw_on_o,
  input logic [NUM_CH-1:0][VAL_W+STEP_W-1:0]        cnt_all
);
  localparam int unsigned CNT_W = VAL_W + STEP_W;
  localparam int unsigned PHASE = (1 << CNT_W) / NUM_CH;
  localparam logic [NUM_CH-1:0] SW_DEFAULT = {NUM_CH{~GRP_RST_ONES}};

  AST_GRP_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && grp_we_i && ch_we_i == '0) |=> (!en_i || sw_on_o == ~$past(grp_wdata_i))); // R2

  AST_REENABLE_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |-> sw_on_o == SW_DEFAULT); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !src_sel_i && !osc_tick_i && !grp_we_i && ch_we_i == '0)
    |=> (!en_i || $stable(sw_on_o))); // R8

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chk
    AST_FORCE_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && ch_we_i[k] && ch_mode_i == 2'd1) |=> (!en_i || sw_on_o[k])); // R3

    AST_FORCE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && ch_we_i[k] && ch_mode_i == 2'd0) |=> !sw_on_o[k]); // R3

    AST_PWM_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(sw_on_o[k]) && en_i && $past(en_i) && !$past(grp_we_i) && $past(ch_we_i) == '0)
      |-> cnt_all[k] == '0); // R5

    if (k > 0) begin : g_stag
      AST_STAGGER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        CNT_W'(cnt_all[k-1] - cnt_all[k]) == CNT_W'(PHASE)); // R6
    end
  end
endmodule

bind stagger_dimmer stagger_dimmer_chk #(
  .NUM_CH       (NUM_CH),
  .VAL_W        (VAL_W),
  .STEP_W       (STEP_W),
  .GRP_RST_ONES (GRP_RST_ONES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .osc_tick_i  (osc_tick_i),
  .src_sel_i   (src_sel_i),
  .grp_we_i    (grp_we_i),
  .grp_wdata_i (grp_wdata_i),
  .ch_we_i     (ch_we_i),
  .ch_mode_i   (ch_mode_i),
  .sw_on_o     (sw_on_o),
  .cnt_all     (cnt_all)
);

// File: tb/stagger_dimmer_test.sv
module stagger_dimmer_test;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC      = 10;
  // {op(1: channel write), ch[2:0], mode[1:0], data[7:0], expected sw_on[7:0]}
  localparam logic [21:0] VEC [N_VEC] = '{
    {1'b0, 3'd0, 2'd0, 8'h00, 8'hFF},
    {1'b0, 3'd0, 2'd0, 8'hA5, 8'h5A},
    {1'b1, 3'd0, 2'd1, 8'h00, 8'h5B},
    {1'b1, 3'd6, 2'd0, 8'h00, 8'h1B},
    {1'b0, 3'd0, 2'd0, 8'h0F, 8'hF0},
    {1'b1, 3'd7, 2'd0, 8'h00, 8'h70},
    {1'b1, 3'd2, 2'd1, 8'h00, 8'h74},
    {1'b0, 3'd0, 2'd0, 8'hFF, 8'h00},
    {1'b1, 3'd5, 2'd1, 8'h00, 8'h20},
    {1'b1, 3'd5, 2'd0, 8'h00, 8'h00}
  };

  logic       clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic       osc_tick = 1'b1, ext_clk = 1'b0, src_sel = 1'b0;
  logic       grp_we = 1'b0;
  logic [7:0] grp_wdata = '0, ch_we = '0, ch_val = '0;
  logic [1:0] ch_mode = '0;
  logic [7:0] sw_on;
  int         checks = 0, errors = 0;
  bit         done = 0, ext_run = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stagger_dimmer uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .osc_tick_i(osc_tick),
    .ext_clk_i(ext_clk), .src_sel_i(src_sel), .grp_we_i(grp_we),
    .grp_wdata_i(grp_wdata), .ch_we_i(ch_we), .ch_mode_i(ch_mode),
    .ch_val_i(ch_val), .sw_on_o(sw_on)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr_grp(input logic [7:0] w);
    @(negedge clk); grp_we = 1'b1; grp_wdata = w;
    @(negedge clk); grp_we = 1'b0;
  endtask

  task automatic wr_ch(input logic [7:0] mask, input logic [1:0] m, input logic [7:0] v);
    @(negedge clk); ch_we = mask; ch_mode = m; ch_val = v;
    @(negedge clk); ch_we = '0;
  endtask

  // wait for a falling edge of one switch, then count low samples
  task automatic measure_low(input int ch, output int len);
    logic prev;
    prev = sw_on[ch];
    forever begin
      @(negedge clk);
      if (prev && !sw_on[ch]) break;
      prev = sw_on[ch];
    end
    len = 0;
    while (!sw_on[ch]) begin
      len++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1..: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int len, bad;
    int fall_t [8];
    logic [7:0] prev, s0;
    int vals [8] = '{1, 0, 64, 128, 255, 200, 3, 100};

    en = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 in reset", sw_on, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", sw_on, 8'h00);

    for (int i = 0; i < N_VEC; i++) begin
      if (VEC[i][21]) begin
        wr_ch(8'(1 << VEC[i][20:18]), VEC[i][17:16], VEC[i][15:8]);
        check($sformatf("R3 vector %0d", i), sw_on, VEC[i][7:0]);
      end else begin
        wr_grp(VEC[i][15:8]);
        check($sformatf("R2 R4 vector %0d", i), sw_on, VEC[i][7:0]);
      end
    end

    // same-cycle group and channel write
    @(negedge clk); grp_we = 1'b1; grp_wdata = 8'h00; ch_we = 8'h02; ch_mode = 2'd0;
    @(negedge clk); grp_we = 1'b0; ch_we = '0;
    check("R4 same-cycle priority", sw_on, 8'hFD);

    wr_grp(8'h00);
    check("R2 group all on", sw_on, 8'hFF);
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    check("R9 disabled forces off", sw_on, 8'h00);
    wr_grp(8'h00);
    wr_ch(8'h0F, 2'd1, 8'd0);
    check("R9 disabled after writes", sw_on, 8'h00);
    @(negedge clk); en = 1'b1;
    @(negedge clk);
    check("R9 writes while disabled discarded", sw_on, 8'h00);

    // stagger after enable rise, all channels PWM at 128
    @(negedge clk); en = 1'b0;
    @(negedge clk); en = 1'b1; ch_we = 8'hFF; ch_mode = 2'd2; ch_val = 8'd128;
    @(negedge clk); ch_we = '0;
    prev = sw_on;
    foreach (fall_t[k]) fall_t[k] = -1;
    for (int i = 2; i <= 2100; i++) begin
      @(negedge clk);
      for (int k = 0; k < 8; k++)
        if (prev[k] && !sw_on[k] && fall_t[k] < 0) fall_t[k] = i;
      prev = sw_on;
    end
    for (int k = 0; k < 8; k++)
      check($sformatf("R6 R1 cycle start of ch%0d", k), fall_t[k], (k == 0) ? 2048 : 256 * k);

    // deferred value load
    measure_low(3, len);
    check("R5 ch3 lit width value 128", len, 1024);
    wr_ch(8'h08, 2'd2, 8'd200);
    bad = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!sw_on[3]) bad++;
    end
    check("R7 mid-cycle value not applied", bad, 0);
    measure_low(3, len);
    check("R7 new value at next cycle", len, 1600);

    // per-channel duty
    for (int k = 0; k < 8; k++) wr_ch(8'(1 << k), 2'd2, 8'(vals[k]));
    for (int k = 0; k < 8; k++) begin
      if (k == 1) continue;
      measure_low(k, len);
      check($sformatf("R5 ch%0d lit width value %0d", k, vals[k]), len, vals[k] * 8);
    end
    bad = 0;
    for (int i = 0; i < 2100; i++) begin
      @(negedge clk);
      if (!sw_on[1]) bad++;
    end
    check("R5 value 0 never lit", bad, 0);

    // external tick source
    @(negedge clk); src_sel = 1'b1;
    @(negedge clk); s0 = sw_on;
    bad = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (sw_on != s0) bad++;
    end
    check("R8 idle external clock holds", bad, 0);
    ext_run = 1;
    fork
      begin
        while (ext_run) begin
          repeat (2) @(negedge clk);
          ext_clk = ~ext_clk;
        end
      end
    join_none
    measure_low(2, len);
    check("R8 external tick rate", len, 64 * 8 * 4);
    ext_run = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule